// File: doc/BRIEF.md
# Page Program Code Sequencer

This block sits on the 8-bit command/address/data bus between a host and a NAND-style flash device. It covers the page program flow. While idle it forwards every host cycle to the flash two clocks late. When the host issues the program setup command, it counts the address strobes and then the data bytes. For each byte inside the protected data area, it gives an external parity generator a one-cycle enable with the sector number, the byte offset and the byte value.

The data phase ends in one of two ways. Either the host has written data plus spare bytes up to the start of the code area, or the host sends the confirm command early. At that point the sequencer takes the flash bus and holds the host busy line low. If the host stopped short, it first pads the page with 0xFF. It then writes three parity bytes per sector, sector by sector, which it fetches from the parity generator through a sector/byte select. It ends by issuing the confirm command itself and then returns to pass-through.

The host is expected to perform full-page writes and to wait for the busy line to rise before it starts another operation. The sector size must be a power of two.

Top module: `pgm_ecc_seq`

## Requirements
- R1: While the sequencer does not own the bus, flash_cle, flash_ale, flash_we_n, flash_re_n and flash_dout equal host_cle, host_ale, host_we_n, host_re_n and host_din as they were two clocks earlier; after reset flash_we_n and flash_re_n are high and flash_cle, flash_ale are low.
- R2: host_dout equals flash_din from two clocks earlier.
- R3: A host command cycle (CLE high, rising WE#) with value 0x80 starts a program sequence; any other command value is only forwarded and starts nothing (no par_start, busy stays high).
- R4: In the data phase, byte n (counted from 0 after the address phase) with n below SECTORS*SECTOR_BYTES produces one par_en pulse with par_sector = n / SECTOR_BYTES, par_byte_idx = n mod SECTOR_BYTES and par_data = the byte; spare bytes produce no pulse.
- R5: After ADDR_CYCLES address strobes (ALE high), par_start pulses exactly once and the byte count restarts at 0.
- R6: When the host has written SECTORS*SECTOR_BYTES+SPARE_BYTES bytes, the sequencer owns the flash bus; further host strobes do not reach the flash.
- R7: Owning the bus, the sequencer writes SECTORS*CODE_PER_SEC code bytes, in the order sector 0 byte 0,1,2, then sector 1, and so on, each taken from code_byte while code_sector/code_byte_sel select it; ALE stays low.
- R8: A host 0x10 command during the data phase is not forwarded; the sequencer pads with 0xFF up to the code area, and padding bytes that fall inside the data area pulse par_en with par_data 0xFF.
- R9: After the last code byte the sequencer writes one command cycle (CLE high) carrying 0x10.
- R10: On every write strobe the sequencer generates, flash_dout does not change from the first low cycle of flash_we_n through its rising edge.
- R11: host_rb_n is low whenever the sequencer owns the bus, and otherwise equals flash_rb_n from two clocks earlier.
- R12: After the confirm command the sequencer returns to pass-through, and a following command or program sequence is handled again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_cle | input | 1 | Host command latch enable |
| host_ale | input | 1 | Host address latch enable |
| host_we_n | input | 1 | Host write strobe, active low |
| host_re_n | input | 1 | Host read strobe, active low |
| host_din | input | 8 | Host write data |
| host_dout | output | 8 | Read data returned to the host |
| host_rb_n | output | 1 | Ready/busy to the host, low = busy |
| flash_cle | output | 1 | Command latch enable to flash |
| flash_ale | output | 1 | Address latch enable to flash |
| flash_we_n | output | 1 | Write strobe to flash |
| flash_re_n | output | 1 | Read strobe to flash |
| flash_dout | output | 8 | Data driven to flash |
| flash_din | input | 8 | Data read from flash |
| flash_rb_n | input | 1 | Flash ready/busy, low = busy |
| par_start | output | 1 | Pulse: clear parity state, data phase begins |
| par_en | output | 1 | Pulse: one byte for the parity generator |
| par_sector | output | clog2(SECTORS) | Sector of the byte |
| par_byte_idx | output | clog2(SECTOR_BYTES) | Offset of the byte within its sector |
| par_data | output | 8 | Byte value for the parity generator |
| code_sector | output | clog2(SECTORS) | Sector whose code byte is selected |
| code_byte_sel | output | clog2(CODE_PER_SEC) | Code byte index within the sector |
| code_byte | input | 8 | Selected code byte from the parity generator |

## Verification
The bench builds the block with two sectors of four bytes, four spare bytes, three code bytes per sector, four address cycles and a 2-low/2-high strobe. A whole page is then 18 bytes. A full write, a short write padded with 0xFF, the sector wrap of par_sector, the exclusion of spare bytes, the code byte order and the final confirm all fit in a few hundred cycles. The default page geometry only changes counter limits, which the same state sequence walks through.

// File: rtl/pgm_ecc_pkg.sv
// Shared definitions for the page program code sequencer.
// Assumes an 8-bit flash bus with the standard program opcodes.
package pgm_ecc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,   // pass-through, watching for program setup
        ST_ADDR,   // counting address strobes
        ST_DATA,   // counting host data bytes
        ST_HAND,   // one-cycle bus hand-over to the sequencer
        ST_FILL,   // padding 0xFF up to the code area
        ST_CODE,   // writing code bytes
        ST_CMD     // writing the confirm command
    } seq_state_t;

    localparam logic [7:0] OP_PROGRAM = 8'h80;
    localparam logic [7:0] OP_CONFIRM = 8'h10;
    localparam logic [7:0] PAD_BYTE   = 8'hFF;

endpackage

// File: rtl/pgm_ecc_sync.sv
// Two-stage input register for the host and flash inputs.
// Assumes inputs may be asynchronous. The low DEC_W bits also expose
// the first stage, which the control logic uses for its decisions.
module pgm_ecc_sync #(
    parameter int W     = 21,
    parameter int DEC_W = 11,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [W-1:0]     d,
    output logic [DEC_W-1:0] q1,
    output logic [W-1:0]     q2
);

    logic [W-1:0] stage1;

    // Shift inputs through two register stages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1 <= RST_VAL;
            q2     <= RST_VAL;
        end else begin
            stage1 <= d;
            q2     <= stage1;
        end
    end

    assign q1 = stage1[DEC_W-1:0];

endmodule

// File: rtl/pgm_ecc_strobe.sv
// Write strobe generator for cycles driven by the sequencer.
// One byte takes LOW+HIGH clocks: one high set-up cycle, LOW low
// cycles, then the rest high. 'last' marks the final cycle of a byte.
// Assumes HIGH >= 2 so data outlives the rising edge by one cycle.
module pgm_ecc_strobe #(
    parameter int LOW  = 2,
    parameter int HIGH = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic we_n,
    output logic last
);

    localparam int T    = LOW + HIGH;
    localparam int PH_W = (T > 1) ? $clog2(T) : 1;
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(T - 1);
    localparam logic [PH_W-1:0] PH_LOW  = PH_W'(LOW);

    logic [PH_W-1:0] phase;

    // Advance the phase while running, restart at zero otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            phase <= '0;
        end else if (phase == PH_LAST) begin
            phase <= '0;
        end else begin
            phase <= phase + 1'b1;
        end
    end

    assign we_n = !(run && (phase != '0) && (phase <= PH_LOW));
    assign last = run && (phase == PH_LAST);

endmodule

// File: rtl/pgm_ecc_code_walk.sv
// Walks the sector / code-byte select across all code bytes of a page.
// Assumes 'clear' comes before the first 'step'.
module pgm_ecc_code_walk #(
    parameter int SECTORS      = 4,
    parameter int CODE_PER_SEC = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic step,
    output logic [((SECTORS > 1) ? $clog2(SECTORS) : 1)-1:0]           sector,
    output logic [((CODE_PER_SEC > 1) ? $clog2(CODE_PER_SEC) : 1)-1:0] byte_sel
);

    localparam int CB_W = (CODE_PER_SEC > 1) ? $clog2(CODE_PER_SEC) : 1;
    localparam logic [CB_W-1:0] CB_LAST = CB_W'(CODE_PER_SEC - 1);

    // Step the byte index, carrying into the sector index.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            sector   <= '0;
            byte_sel <= '0;
        end else if (step) begin
            if (byte_sel == CB_LAST) begin
                byte_sel <= '0;
                sector   <= sector + 1'b1;
            end else begin
                byte_sel <= byte_sel + 1'b1;
            end
        end
    end

endmodule

// File: rtl/pgm_ecc_seq.sv
// Page program code sequencer. Forwards host bus cycles to the flash,
// counts program data bytes for an external parity generator, then takes
// the bus to pad, write the code bytes and issue the confirm command.
// Assumes full-page host writes and SECTOR_BYTES a power of two.
module pgm_ecc_seq
    import pgm_ecc_pkg::*;
#(
    parameter int SECTOR_BYTES = 512,
    parameter int SECTORS      = 4,
    parameter int SPARE_BYTES  = 52,
    parameter int CODE_PER_SEC = 3,
    parameter int ADDR_CYCLES  = 4,
    parameter int STROBE_LOW   = 2,
    parameter int STROBE_HIGH  = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       host_cle,
    input  logic       host_ale,
    input  logic       host_we_n,
    input  logic       host_re_n,
    input  logic [7:0] host_din,
    output logic [7:0] host_dout,
    output logic       host_rb_n,
    output logic       flash_cle,
    output logic       flash_ale,
    output logic       flash_we_n,
    output logic       flash_re_n,
    output logic [7:0] flash_dout,
    input  logic [7:0] flash_din,
    input  logic       flash_rb_n,
    output logic       par_start,
    output logic       par_en,
    output logic [((SECTORS > 1) ? $clog2(SECTORS) : 1)-1:0]           par_sector,
    output logic [$clog2(SECTOR_BYTES)-1:0]                            par_byte_idx,
    output logic [7:0] par_data,
    output logic [((SECTORS > 1) ? $clog2(SECTORS) : 1)-1:0]           code_sector,
    output logic [((CODE_PER_SEC > 1) ? $clog2(CODE_PER_SEC) : 1)-1:0] code_byte_sel,
    input  logic [7:0] code_byte
);

    localparam int DATA_BYTES = SECTOR_BYTES * SECTORS;
    localparam int CODE_START = DATA_BYTES + SPARE_BYTES;
    localparam int CODE_END   = CODE_START + SECTORS * CODE_PER_SEC;
    localparam int CNT_W      = $clog2(CODE_END + 1);
    localparam int SEC_AW     = $clog2(SECTOR_BYTES);
    localparam int SEC_SEL_W  = (SECTORS > 1) ? $clog2(SECTORS) : 1;
    localparam int AC_W       = $clog2(ADDR_CYCLES + 1);
    localparam int DEC_W      = 11;
    localparam int SYNC_W     = DEC_W + 10;

    localparam logic [CNT_W-1:0] DATA_C       = CNT_W'(DATA_BYTES);
    localparam logic [CNT_W-1:0] START_LAST_C = CNT_W'(CODE_START - 1);
    localparam logic [CNT_W-1:0] CODE_START_C = CNT_W'(CODE_START);
    localparam logic [CNT_W-1:0] END_LAST_C   = CNT_W'(CODE_END - 1);
    localparam logic [AC_W-1:0]  ADDR_LAST_C  = AC_W'(ADDR_CYCLES - 1);

    // Reset image: strobes and ready high, everything else low.
    localparam logic [SYNC_W-1:0] SYNC_RST = {8'h00, 1'b1, 1'b1, 8'h00, 1'b1, 1'b0, 1'b0};

    // ---------------- input registers ----------------
    logic [DEC_W-1:0]  s1;
    logic [SYNC_W-1:0] s2;

    pgm_ecc_sync #(.W(SYNC_W), .DEC_W(DEC_W), .RST_VAL(SYNC_RST)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({flash_din, flash_rb_n, host_re_n, host_din, host_we_n, host_ale, host_cle}),
        .q1    (s1),
        .q2    (s2)
    );

    logic       s1_cle, s1_ale, s1_we_n;
    logic [7:0] s1_din;
    logic       s2_cle, s2_ale, s2_we_n, s2_re_n, s2_rb_n;
    logic [7:0] s2_din, s2_fdin;

    assign {s1_din, s1_we_n, s1_ale, s1_cle} = s1;
    assign {s2_fdin, s2_rb_n, s2_re_n, s2_din, s2_we_n, s2_ale, s2_cle} = s2;

    // Host strobe edges as seen at the first stage.
    logic w_rise, w_fall;
    assign w_rise = s1_we_n && !s2_we_n;
    assign w_fall = !s1_we_n && s2_we_n;

    // ---------------- control state ----------------
    seq_state_t       state;
    logic [CNT_W-1:0] byte_cnt;
    logic [AC_W-1:0]  addr_cnt;
    logic             bus_own;
    logic             stb_run, stb_we_n, stb_last;
    logic             par_en_q, par_start_q;
    logic [7:0]       par_data_q;
    logic [SEC_AW-1:0]    par_idx_q;
    logic [SEC_SEL_W-1:0] par_sec_q;

    assign bus_own = (state == ST_HAND) || (state == ST_FILL) ||
                     (state == ST_CODE) || (state == ST_CMD);
    assign stb_run = (state == ST_FILL) || (state == ST_CODE) || (state == ST_CMD);

    pgm_ecc_strobe #(.LOW(STROBE_LOW), .HIGH(STROBE_HIGH)) u_strobe (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (stb_run),
        .we_n  (stb_we_n),
        .last  (stb_last)
    );

    pgm_ecc_code_walk #(.SECTORS(SECTORS), .CODE_PER_SEC(CODE_PER_SEC)) u_walk (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (state == ST_HAND),
        .step     ((state == ST_CODE) && stb_last),
        .sector   (code_sector),
        .byte_sel (code_byte_sel)
    );

    // Sequence the program flow and count bytes; emit parity pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= ST_IDLE;
            byte_cnt    <= '0;
            addr_cnt    <= '0;
            par_en_q    <= 1'b0;
            par_start_q <= 1'b0;
            par_data_q  <= '0;
            par_idx_q   <= '0;
            par_sec_q   <= '0;
        end else begin
            par_en_q    <= 1'b0;
            par_start_q <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (w_rise && s1_cle && (s1_din == OP_PROGRAM)) begin
                        state    <= ST_ADDR;
                        addr_cnt <= '0;
                    end
                end
                ST_ADDR: begin
                    if (w_rise && s1_cle) begin
                        state <= ST_IDLE;
                    end else if (w_rise && s1_ale) begin
                        if (addr_cnt == ADDR_LAST_C) begin
                            state       <= ST_DATA;
                            byte_cnt    <= '0;
                            par_start_q <= 1'b1;
                        end else begin
                            addr_cnt <= addr_cnt + 1'b1;
                        end
                    end
                end
                ST_DATA: begin
                    if (w_fall && s1_cle && (s1_din == OP_CONFIRM)) begin
                        state <= ST_HAND;
                    end else if (w_rise && !s1_cle && !s1_ale) begin
                        if (byte_cnt < DATA_C) begin
                            par_en_q   <= 1'b1;
                            par_data_q <= s1_din;
                            par_idx_q  <= byte_cnt[SEC_AW-1:0];
                            par_sec_q  <= byte_cnt[SEC_AW +: SEC_SEL_W];
                        end
                        byte_cnt <= byte_cnt + 1'b1;
                        if (byte_cnt == START_LAST_C) begin
                            state <= ST_HAND;
                        end
                    end
                end
                ST_HAND: begin
                    state <= (byte_cnt < CODE_START_C) ? ST_FILL : ST_CODE;
                end
                ST_FILL: begin
                    if (stb_last) begin
                        if (byte_cnt < DATA_C) begin
                            par_en_q   <= 1'b1;
                            par_data_q <= PAD_BYTE;
                            par_idx_q  <= byte_cnt[SEC_AW-1:0];
                            par_sec_q  <= byte_cnt[SEC_AW +: SEC_SEL_W];
                        end
                        byte_cnt <= byte_cnt + 1'b1;
                        if (byte_cnt == START_LAST_C) begin
                            state <= ST_CODE;
                        end
                    end
                end
                ST_CODE: begin
                    if (stb_last) begin
                        byte_cnt <= byte_cnt + 1'b1;
                        if (byte_cnt == END_LAST_C) begin
                            state <= ST_CMD;
                        end
                    end
                end
                ST_CMD: begin
                    if (stb_last) begin
                        state <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Select pass-through or sequencer-driven flash bus.
    always_comb begin
        flash_cle  = s2_cle;
        flash_ale  = s2_ale;
        flash_we_n = s2_we_n;
        flash_re_n = s2_re_n;
        flash_dout = s2_din;
        if (bus_own) begin
            flash_cle  = (state == ST_CMD);
            flash_ale  = 1'b0;
            flash_re_n = 1'b1;
            flash_we_n = (state == ST_HAND) ? 1'b1 : stb_we_n;
            unique case (state)
                ST_FILL: flash_dout = PAD_BYTE;
                ST_CODE: flash_dout = code_byte;
                ST_CMD:  flash_dout = OP_CONFIRM;
                default: flash_dout = s2_din;
            endcase
        end
    end

    assign host_rb_n    = s2_rb_n && !bus_own;
    assign host_dout    = s2_fdin;
    assign par_start    = par_start_q;
    assign par_en       = par_en_q;
    assign par_data     = par_data_q;
    assign par_byte_idx = par_idx_q;
    assign par_sector   = par_sec_q;

endmodule

// File: rtl/pgm_ecc_seq_chk.sv
// Property checker for the page program code sequencer, bound to the top.
// Assumes the bus ownership flag of the top is connected as 'own'.
module pgm_ecc_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       host_we_n,
    input logic       host_rb_n,
    input logic       flash_we_n,
    input logic       flash_cle,
    input logic       flash_ale,
    input logic [7:0] flash_dout,
    input logic [7:0] flash_din,
    input logic [7:0] host_dout,
    input logic       flash_rb_n,
    input logic       own
);

    logic [1:0] warm_cnt;
    logic       warm;

    // Count clocks since reset so two-deep history is valid.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            warm_cnt <= '0;
        end else if (warm_cnt != 2'd2) begin
            warm_cnt <= warm_cnt + 1'b1;
        end
    end
    assign warm = (warm_cnt == 2'd2);

    AST_PASS_WE_LAG: assert property (@(posedge clk) disable iff (!rst_n)
        (warm && !own) |-> (flash_we_n == $past(host_we_n, 2))); // R1

    AST_READ_LAG: assert property (@(posedge clk) disable iff (!rst_n)
        warm |-> (host_dout == $past(flash_din, 2))); // R2

    AST_BUSY_OWN: assert property (@(posedge clk) disable iff (!rst_n)
        own |-> !host_rb_n); // R11

    AST_RB_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (warm && !own) |-> (host_rb_n == $past(flash_rb_n, 2))); // R11

    AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (own && !flash_we_n) |=> $stable(flash_dout)); // R10

    AST_NO_ADDR_OWN: assert property (@(posedge clk) disable iff (!rst_n)
        own |-> !flash_ale); // R7

    AST_CONFIRM_VAL: assert property (@(posedge clk) disable iff (!rst_n)
        (own && flash_cle) |-> (flash_dout == 8'h10)); // R9

endmodule

bind pgm_ecc_seq pgm_ecc_seq_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_we_n  (host_we_n),
    .host_rb_n  (host_rb_n),
    .flash_we_n (flash_we_n),
    .flash_cle  (flash_cle),
    .flash_ale  (flash_ale),
    .flash_dout (flash_dout),
    .flash_din  (flash_din),
    .host_dout  (host_dout),
    .flash_rb_n (flash_rb_n),
    .own        (bus_own)
);

// File: tb/sim_pgm_ecc_seq.sv
// Directed bench: small page (2 sectors x 4 bytes, 4 spare, 3 code/sector).
module sim_pgm_ecc_seq;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_cle = 1'b0, host_ale = 1'b0, host_we_n = 1'b1, host_re_n = 1'b1;
    logic [7:0] host_din = 8'h00;
    logic [7:0] host_dout;
    logic       host_rb_n;
    logic       flash_cle, flash_ale, flash_we_n, flash_re_n;
    logic [7:0] flash_dout;
    logic [7:0] flash_din = 8'h00;
    logic       flash_rb_n = 1'b1;
    logic       par_start, par_en;
    logic [0:0] par_sector, code_sector;
    logic [1:0] par_byte_idx, code_byte_sel;
    logic [7:0] par_data, code_byte;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    assign code_byte = 8'hC0 | {5'd0, code_sector, code_byte_sel};

    pgm_ecc_seq #(
        .SECTOR_BYTES(4), .SECTORS(2), .SPARE_BYTES(4), .CODE_PER_SEC(3),
        .ADDR_CYCLES(4), .STROBE_LOW(2), .STROBE_HIGH(2)
    ) u0 (
        .clk(clk), .rst_n(rst_n),
        .host_cle(host_cle), .host_ale(host_ale), .host_we_n(host_we_n),
        .host_re_n(host_re_n), .host_din(host_din), .host_dout(host_dout),
        .host_rb_n(host_rb_n),
        .flash_cle(flash_cle), .flash_ale(flash_ale), .flash_we_n(flash_we_n),
        .flash_re_n(flash_re_n), .flash_dout(flash_dout), .flash_din(flash_din),
        .flash_rb_n(flash_rb_n),
        .par_start(par_start), .par_en(par_en), .par_sector(par_sector),
        .par_byte_idx(par_byte_idx), .par_data(par_data),
        .code_sector(code_sector), .code_byte_sel(code_byte_sel), .code_byte(code_byte)
    );

    // Flash-side write log and parity log, sampled at the falling edge.
    logic [9:0] wlog [0:63];
    logic [10:0] plog [0:63];
    int nlog = 0, npar = 0, nstart = 0;
    logic prev_we = 1'b1;

    always @(negedge clk) begin
        if (rst_n && !prev_we && flash_we_n && nlog < 64) begin
            wlog[nlog] = {flash_cle, flash_ale, flash_dout};
            nlog = nlog + 1;
        end
        prev_we = flash_we_n;
        if (rst_n && par_en && npar < 64) begin
            plog[npar] = {par_sector, par_byte_idx, par_data};
            npar = npar + 1;
        end
        if (rst_n && par_start) nstart = nstart + 1;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic clear_logs();
        nlog = 0; npar = 0; nstart = 0;
    endtask

    task automatic host_write(input logic cle, input logic ale, input logic [7:0] d);
        @(negedge clk); host_cle = cle; host_ale = ale; host_din = d;
        @(negedge clk); host_we_n = 1'b0;
        repeat (3) @(negedge clk);
        host_we_n = 1'b1;
        repeat (3) @(negedge clk);
        host_cle = 1'b0; host_ale = 1'b0;
    endtask

    task automatic wait_ready();
        for (int i = 0; i < 400 && !host_rb_n; i++) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    task automatic check_log(input int idx, input logic [9:0] exp, input string req);
        chk(wlog[idx] === exp, req, int'(wlog[idx]), int'(exp));
    endtask

    // Reset values and the two-clock pass-through lag.
    task automatic t_reset_and_lag();
        chk(flash_we_n === 1'b1 && flash_re_n === 1'b1 && flash_cle === 1'b0 && flash_ale === 1'b0,
            "R1 reset outputs", {flash_we_n, flash_re_n, flash_cle, flash_ale}, 4'b1100);
        chk(host_rb_n === 1'b1, "R11 reset ready", host_rb_n, 1);
        chk(par_en === 1'b0, "R4 reset par_en", par_en, 0);
        @(negedge clk); host_re_n = 1'b0; flash_din = 8'h5A;
        @(negedge clk);
        chk(flash_re_n === 1'b1, "R1 lag one clock", flash_re_n, 1);
        @(negedge clk);
        chk(flash_re_n === 1'b0, "R1 lag two clocks", flash_re_n, 0);
        chk(host_dout === 8'h5A, "R2 read data", host_dout, 8'h5A);
        host_re_n = 1'b1;
        flash_rb_n = 1'b0;
        repeat (2) @(negedge clk);
        chk(host_rb_n === 1'b0, "R11 flash busy forwarded", host_rb_n, 0);
        flash_rb_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(host_rb_n === 1'b1, "R11 flash ready forwarded", host_rb_n, 1);
    endtask

    // Non-program commands are forwarded and start nothing.
    task automatic t_other_cmds();
        clear_logs();
        host_write(1'b1, 1'b0, 8'h90);
        host_write(1'b1, 1'b0, 8'h60);
        host_write(1'b0, 1'b0, 8'h33);
        repeat (4) @(negedge clk);
        chk(nlog == 3, "R3 forwarded cycle count", nlog, 3);
        check_log(0, {2'b10, 8'h90}, "R3 command forwarded");
        check_log(2, {2'b00, 8'h33}, "R3 data forwarded idle");
        chk(nstart == 0 && npar == 0, "R3 no sequence started", nstart + npar, 0);
        chk(host_rb_n === 1'b1, "R3 stays ready", host_rb_n, 1);
    endtask

    // Full page write: data+spare, then code bytes and confirm.
    task automatic t_full_page();
        clear_logs();
        host_write(1'b1, 1'b0, 8'h80);
        for (int i = 0; i < 4; i++) host_write(1'b0, 1'b1, 8'hA0 + 8'(i));
        for (int i = 0; i < 12; i++) host_write(1'b0, 1'b0, 8'h30 + 8'(i));
        chk(host_rb_n === 1'b0, "R6 busy after last byte", host_rb_n, 0);
        host_write(1'b0, 1'b0, 8'hEE);
        wait_ready();
        chk(nstart == 1, "R5 single par_start", nstart, 1);
        chk(nlog == 24, "R6 flash write count", nlog, 24);
        check_log(0, {2'b10, 8'h80}, "R3 program setup forwarded");
        for (int i = 0; i < 4; i++) check_log(1 + i, {2'b01, 8'hA0 + 8'(i)}, "R5 address cycle");
        for (int i = 0; i < 12; i++) check_log(5 + i, {2'b00, 8'h30 + 8'(i)}, "R6 data forwarded");
        for (int s = 0; s < 2; s++)
            for (int b = 0; b < 3; b++)
                check_log(17 + s * 3 + b, {2'b00, 8'hC0 | 8'(s * 4 + b)}, "R7 code byte order");
        check_log(23, {2'b10, 8'h10}, "R9 confirm command");
        chk(npar == 8, "R4 spare excluded from parity", npar, 8);
        for (int n = 0; n < 8; n++)
            chk(plog[n] === {1'(n / 4), 2'(n % 4), 8'h30 + 8'(n)}, "R4 parity index and data",
                int'(plog[n]), int'({1'(n / 4), 2'(n % 4), 8'h30 + 8'(n)}));
        chk(host_rb_n === 1'b1, "R12 ready after confirm", host_rb_n, 1);
    endtask

    // After a page, pass-through works again.
    task automatic t_back_to_idle();
        clear_logs();
        host_write(1'b1, 1'b0, 8'h70);
        repeat (4) @(negedge clk);
        chk(nlog == 1 && wlog[0] === {2'b10, 8'h70}, "R12 pass-through resumed",
            int'(wlog[0]), int'({2'b10, 8'h70}));
    endtask

    // Short write with early confirm: padding then code then confirm.
    task automatic t_short_page();
        clear_logs();
        host_write(1'b1, 1'b0, 8'h80);
        for (int i = 0; i < 4; i++) host_write(1'b0, 1'b1, 8'hB0 + 8'(i));
        for (int i = 0; i < 5; i++) host_write(1'b0, 1'b0, 8'h40 + 8'(i));
        host_write(1'b1, 1'b0, 8'h10);
        chk(host_rb_n === 1'b0, "R8 busy after early confirm", host_rb_n, 0);
        wait_ready();
        chk(nlog == 24, "R8 flash write count", nlog, 24);
        for (int i = 0; i < 5; i++) check_log(5 + i, {2'b00, 8'h40 + 8'(i)}, "R8 short data");
        for (int i = 0; i < 7; i++) check_log(10 + i, {2'b00, 8'hFF}, "R8 padding byte");
        check_log(17, {2'b00, 8'hC0}, "R7 first code byte");
        check_log(22, {2'b00, 8'hC6}, "R7 last code byte");
        check_log(23, {2'b10, 8'h10}, "R9 single confirm");
        chk(npar == 8, "R8 parity count with padding", npar, 8);
        for (int n = 5; n < 8; n++)
            chk(plog[n] === {1'(n / 4), 2'(n % 4), 8'hFF}, "R8 padding feeds parity",
                int'(plog[n]), int'({1'(n / 4), 2'(n % 4), 8'hFF}));
    endtask

    bit done = 1'b0;

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_and_lag();
        t_other_cmds();
        t_full_page();
        t_back_to_idle();
        t_short_page();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks = checks + 1;
            errors = errors + 1;
            $display("FAIL watchdog actual=0x0 expected=0x1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule